// File: doc/BRIEF.md
# Dual Potentiometer Command Executor

This block sits behind a two-wire serial slave front-end and carries out the register commands for two digitally set wiper channels. Each channel holds one volatile 6-bit wiper value, which sets the tap position, and four 6-bit stored settings that behave as nonvolatile cells. The front-end handles the bus and the address match. It then hands over bus start and stop events and the bytes that follow the address. The first byte after a start is the command byte. An optional second byte carries data.

State changes are applied when the stop that ends the command arrives. A stop that ends a store command (one that changes a stored setting) starts a write timer that models the nonvolatile write time. While that timer runs, the busy flag tells the front-end to refuse traffic, and the executor ignores any bytes it sees. One command puts the block into a stepping mode. In that mode the front-end forwards one step pulse per clock pulse, with a direction, and each pulse moves the chosen wiper by one tap.

Top module: `dpot_exec`

## Requirements
- R1: After reset, `busy_o` and `incdec_o` are low. Stored setting k of pot p holds its `DR_INIT` field. With the default, pot 0 holds 10, 20, 30, 40 and pot 1 holds 5, 15, 25, 35 for settings 0 to 3. Each wiper holds its pot's setting 0.
- R2: The command byte is split as follows: bits 7..4 are the opcode, bit 2 selects the pot, and bits 1..0 select the stored setting. Opcode 1001 reads the selected wiper. From the cycle after the command byte is accepted, `rd_data_o` shows that value zero-extended to 8 bits.
- R3: Opcode 1011 reads the selected stored setting onto `rd_data_o` the same way.
- R4: Opcode 1010 followed by a data byte loads bits 5..0 of the data byte into the selected wiper when the stop arrives. If the stop comes before the data byte, the command has no effect.
- R5: Opcode 1100 followed by a data byte stores bits 5..0 of the data byte into the selected setting at the stop. From the cycle after that stop, `busy_o` stays high for exactly `WR_CYCLES` cycles.
- R6: Opcode 1101 copies the selected setting of the selected pot into that pot's wiper. Opcode 1110 copies that pot's wiper into its selected setting and starts the write timer. Both take effect at the stop.
- R7: Opcode 0001 copies setting R of each pot into that pot's wiper. Opcode 1000 copies each wiper into setting R of its own pot and starts the write timer. Bit 2 is ignored for both opcodes.
- R8: While `busy_o` is high, bytes and stops have no effect on any register.
- R9: Opcode 0010 raises `incdec_o` for the selected pot. Each `step_i` pulse then moves that wiper up by one when `step_up_i` is 1, or down by one when it is 0, saturating at 0 and 63. A start or a stop ends the mode, and step pulses outside the mode are ignored.
- R10: Undefined opcodes change nothing and do not start the timer. A repeated start before the stop discards the pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also serves as power-up recall |
| start_i | input | 1 | Bus start (or repeated start) event after an address match |
| stop_i | input | 1 | Bus stop event |
| byte_vld_i | input | 1 | One-cycle strobe for a received byte |
| byte_i | input | 8 | Received byte |
| step_i | input | 1 | One-cycle step pulse while in stepping mode |
| step_up_i | input | 1 | Step direction, 1 = toward the top end |
| rd_data_o | output | 8 | Value to transmit for read commands |
| busy_o | output | 1 | Nonvolatile write in progress |
| incdec_o | output | 1 | Stepping mode active |
| wiper0_o | output | 6 | Wiper position of pot 0 |
| wiper1_o | output | 6 | Wiper position of pot 1 |

## Verification
The bench checks that a wiper does not change between the data byte and the stop. A design that applied writes as soon as the byte arrived would move the wiper early. It also ends a write command before its data byte and issues a repeated start with a command pending. A design that committed partial commands would write stale data in these cases. Other tests count the exact busy length and send traffic during the busy window, which exposes an off-by-one timer or a design that lets writes slip through the lockout. Stepping is driven past both ends of the range to catch wrap-around, and the global opcodes are sent with the pot bit set to confirm that both pots move together.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int NPOT = 2;

    localparam logic [3:0] OP_GDR2W  = 4'b0001;
    localparam logic [3:0] OP_INCDEC = 4'b0010;
    localparam logic [3:0] OP_GW2DR  = 4'b1000;
    localparam logic [3:0] OP_RDW    = 4'b1001;
    localparam logic [3:0] OP_WRW    = 4'b1010;
    localparam logic [3:0] OP_RDDR   = 4'b1011;
    localparam logic [3:0] OP_WRDR   = 4'b1100;
    localparam logic [3:0] OP_DR2W   = 4'b1101;
    localparam logic [3:0] OP_W2DR   = 4'b1110;

    function automatic logic is_store(input logic [3:0] op);
        return (op == OP_WRDR) || (op == OP_W2DR) || (op == OP_GW2DR);
    endfunction
endpackage

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int WIPER_W = 6,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               byte_vld_i,
    input  logic [7:0]         byte_i,
    input  logic               step_i,
    input  logic               busy_i,
    output logic               commit_o,
    output logic               store_o,
    output logic               step_en_o,
    output logic               incdec_o,
    output logic [3:0]         op_o,
    output logic               pot_o,
    output logic [SEL_W-1:0]   rsel_o,
    output logic [WIPER_W-1:0] data_o
);
    typedef struct packed {
        logic               have_cmd;
        logic               have_data;
        logic               incdec;
        logic [3:0]         op;
        logic               pot;
        logic [SEL_W-1:0]   rsel;
        logic [WIPER_W-1:0] data;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  pend_ok;

    always_comb begin
        pend_ok = 1'b0;
        if (s_q.have_cmd) begin
            case (s_q.op)
                OP_WRW, OP_WRDR:                      pend_ok = s_q.have_data;
                OP_DR2W, OP_W2DR, OP_GDR2W, OP_GW2DR: pend_ok = 1'b1;
                default:                              pend_ok = 1'b0;
            endcase
        end

        s_d      = s_q;
        commit_o = 1'b0;
        if (stop_i) begin
            commit_o    = pend_ok && !busy_i;
            s_d.have_cmd  = 1'b0;
            s_d.have_data = 1'b0;
            s_d.incdec    = 1'b0;
        end else if (start_i) begin
            s_d.have_cmd  = 1'b0;
            s_d.have_data = 1'b0;
            s_d.incdec    = 1'b0;
        end else if (byte_vld_i && !busy_i) begin
            if (!s_q.have_cmd) begin
                s_d.have_cmd = 1'b1;
                s_d.op       = byte_i[7:4];
                s_d.pot      = byte_i[2];
                s_d.rsel     = byte_i[SEL_W-1:0];
                s_d.incdec   = (byte_i[7:4] == OP_INCDEC);
            end else if (!s_q.have_data) begin
                s_d.have_data = 1'b1;
                s_d.data      = byte_i[WIPER_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign store_o   = commit_o && is_store(s_q.op);
    assign step_en_o = step_i && s_q.incdec && !busy_i;
    assign incdec_o  = s_q.incdec;
    assign op_o      = s_q.op;
    assign pot_o     = s_q.pot;
    assign rsel_o    = s_q.rsel;
    assign data_o    = s_q.data;

    // R8: nothing is committed during the write lockout
    a_r8_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !commit_o);
    // R9: stepping mode ends on a start or stop
    a_r9_mode_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || stop_i) |=> !incdec_o);
endmodule

// File: rtl/dpot_bank.sv
module dpot_bank
    import dpot_pkg::*;
#(
    parameter int WIPER_W = 6,
    parameter int NREG    = 4,
    parameter logic [NPOT*NREG*WIPER_W-1:0] DR_INIT = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit_i,
    input  logic [3:0]                   op_i,
    input  logic                         pot_i,
    input  logic [$clog2(NREG)-1:0]      rsel_i,
    input  logic [WIPER_W-1:0]           data_i,
    input  logic                         step_en_i,
    input  logic                         step_up_i,
    output logic [NPOT-1:0][WIPER_W-1:0] wip_o,
    output logic [NPOT-1:0][NREG-1:0][WIPER_W-1:0] dr_o
);
    localparam logic [WIPER_W-1:0] WMAX = '1;

    typedef struct packed {
        logic [NPOT-1:0][WIPER_W-1:0]            wip;
        logic [NPOT-1:0][NREG-1:0][WIPER_W-1:0]  dr;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        for (int p = 0; p < NPOT; p++) begin
            if (commit_i) begin
                case (op_i)
                    OP_WRW:   if (pot_i == 1'(p)) b_d.wip[p] = data_i;
                    OP_WRDR:  if (pot_i == 1'(p)) b_d.dr[p][rsel_i] = data_i;
                    OP_DR2W:  if (pot_i == 1'(p)) b_d.wip[p] = b_q.dr[p][rsel_i];
                    OP_W2DR:  if (pot_i == 1'(p)) b_d.dr[p][rsel_i] = b_q.wip[p];
                    OP_GDR2W: b_d.wip[p] = b_q.dr[p][rsel_i];
                    OP_GW2DR: b_d.dr[p][rsel_i] = b_q.wip[p];
                    default:  ;
                endcase
            end
            if (step_en_i && pot_i == 1'(p)) begin
                if (step_up_i && b_q.wip[p] != WMAX)
                    b_d.wip[p] = b_q.wip[p] + 1'b1;
                else if (!step_up_i && b_q.wip[p] != '0)
                    b_d.wip[p] = b_q.wip[p] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPOT; p++) begin
                b_q.wip[p] <= DR_INIT[p*NREG*WIPER_W +: WIPER_W];
                for (int r = 0; r < NREG; r++)
                    b_q.dr[p][r] <= DR_INIT[(p*NREG+r)*WIPER_W +: WIPER_W];
            end
        end else begin
            b_q <= b_d;
        end
    end

    assign wip_o = b_q.wip;
    assign dr_o  = b_q.dr;

    // R5: stored settings change only on a committed store command
    a_r5_dr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_i && is_store(op_i)) |=> $stable(b_q.dr));
    // R9: an up step at the top end leaves the wiper at the top
    a_r9_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && step_up_i && !commit_i && b_q.wip[pot_i] == WMAX)
        |=> b_q.wip[$past(pot_i)] == WMAX);
    // R9: a down step at zero leaves the wiper at zero
    a_r9_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !step_up_i && !commit_i && b_q.wip[pot_i] == '0)
        |=> b_q.wip[$past(pot_i)] == '0);
endmodule

// File: rtl/dpot_nvtimer.sv
module dpot_nvtimer #(
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)          cnt_d = CW'(WR_CYCLES);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R5: a store commit raises busy on the next cycle
    a_r5_busy_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

// File: rtl/dpot_exec.sv
module dpot_exec
    import dpot_pkg::*;
#(
    parameter int WIPER_W   = 6,
    parameter int NREG      = 4,
    parameter int WR_CYCLES = 500000,
    parameter logic [NPOT*NREG*WIPER_W-1:0] DR_INIT =
        {6'd35, 6'd25, 6'd15, 6'd5, 6'd40, 6'd30, 6'd20, 6'd10}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               byte_vld_i,
    input  logic [7:0]         byte_i,
    input  logic               step_i,
    input  logic               step_up_i,
    output logic [7:0]         rd_data_o,
    output logic               busy_o,
    output logic               incdec_o,
    output logic [WIPER_W-1:0] wiper0_o,
    output logic [WIPER_W-1:0] wiper1_o
);
    localparam int SEL_W = $clog2(NREG);

    logic               commit, store, step_en, pot;
    logic [3:0]         op;
    logic [SEL_W-1:0]   rsel;
    logic [WIPER_W-1:0] data;
    logic [NPOT-1:0][WIPER_W-1:0]           wip;
    logic [NPOT-1:0][NREG-1:0][WIPER_W-1:0] dr;

    dpot_ctrl #(.WIPER_W(WIPER_W), .SEL_W(SEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .step_i(step_i),
        .busy_i(busy_o), .commit_o(commit), .store_o(store),
        .step_en_o(step_en), .incdec_o(incdec_o), .op_o(op), .pot_o(pot),
        .rsel_o(rsel), .data_o(data)
    );

    dpot_bank #(.WIPER_W(WIPER_W), .NREG(NREG), .DR_INIT(DR_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .op_i(op), .pot_i(pot),
        .rsel_i(rsel), .data_i(data), .step_en_i(step_en),
        .step_up_i(step_up_i), .wip_o(wip), .dr_o(dr)
    );

    dpot_nvtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(store), .busy_o(busy_o)
    );

    logic [WIPER_W-1:0] rd_val;
    always_comb begin
        rd_val = (op == OP_RDW) ? wip[pot] : dr[pot][rsel];
    end

    assign rd_data_o = 8'(rd_val);
    assign wiper0_o  = wip[0];
    assign wiper1_o  = wip[1];
endmodule

// File: tb/tb_dpot_exec.sv
module tb_dpot_exec;
    localparam int CLK_PERIOD = 10;
    localparam int WRC        = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       step_i = 1'b0, step_up_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       busy_o, incdec_o;
    logic [5:0] wiper0_o, wiper1_o;

    int checks = 0;
    int fails  = 0;
    int rw[2];
    int rdr[2][4];

    dpot_exec #(.WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .step_i(step_i),
        .step_up_i(step_up_i), .rd_data_o(rd_data_o), .busy_o(busy_o),
        .incdec_o(incdec_o), .wiper0_o(wiper0_o), .wiper1_o(wiper1_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask
    task automatic do_stop();
        @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    endtask
    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); byte_i = b; byte_vld_i = 1'b1;
        @(negedge clk); byte_vld_i = 1'b0;
    endtask
    task automatic do_step(input logic up);
        @(negedge clk); step_i = 1'b1; step_up_i = up;
        @(negedge clk); step_i = 1'b0;
    endtask

    task automatic chk_wipers(input string req);
        chk({req, " wiper0"}, wiper0_o, rw[0]);
        chk({req, " wiper1"}, wiper1_o, rw[1]);
    endtask

    task automatic read_dr(input string req, input int p, input int r);
        do_start();
        do_byte({4'b1011, 1'b0, 1'(p), 2'(r)});
        chk(req, rd_data_o, rdr[p][r]);
        do_stop();
    endtask

    // stop already driven; counts busy cycles from the first one
    task automatic busy_len(input string req);
        int n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(posedge clk); #1;
        end
        chk(req, n, WRC);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rw[0] = 10; rw[1] = 5;
        for (int r = 0; r < 4; r++) begin
            rdr[0][r] = 10 * (r + 1);
            rdr[1][r] = 5 + 10 * r;
        end
        chk("R1 busy", busy_o, 0);
        chk("R1 incdec", incdec_o, 0);
        chk_wipers("R1");
        read_dr("R1 pot1 setting3", 1, 3);
    endtask

    task automatic t_reads();
        do_start(); do_byte(8'h94);
        chk("R2 read wiper1", rd_data_o, rw[1]);
        do_stop();
        do_start(); do_byte(8'h90);
        chk("R2 read wiper0", rd_data_o, rw[0]);
        do_stop();
        read_dr("R3 pot0 setting2", 0, 2);
    endtask

    task automatic t_write_wcr();
        do_start(); do_byte(8'hA0); do_byte(8'hFF);
        chk("R4 no change before stop", wiper0_o, rw[0]);
        do_stop(); rw[0] = 63;
        chk_wipers("R4 write wiper0");
        do_start(); do_byte(8'hA4); do_stop();
        chk_wipers("R4 truncated write");
    endtask

    task automatic t_write_dr();
        do_start(); do_byte(8'hC5); do_byte(8'h2A);
        @(negedge clk); stop_i = 1'b1; @(posedge clk); #1; stop_i = 1'b0;
        rdr[1][1] = 42;
        busy_len("R5 busy length");
        read_dr("R5 pot1 setting1", 1, 1);
        // traffic during lockout
        do_start(); do_byte(8'hC4); do_byte(8'h01);
        @(negedge clk); stop_i = 1'b1; @(posedge clk); #1; stop_i = 1'b0;
        rdr[1][0] = 1;
        do_start(); do_byte(8'hA0); do_byte(8'h07); do_stop();
        chk_wipers("R8 write ignored while busy");
        chk("R8 still busy", busy_o, 1);
        while (busy_o) @(negedge clk);
        read_dr("R8 pot1 setting0", 1, 0);
    endtask

    task automatic t_xfr();
        do_start(); do_byte(8'hD6); do_stop();
        rw[1] = rdr[1][2];
        chk_wipers("R6 setting to wiper");
        do_start(); do_byte(8'hE1);
        @(negedge clk); stop_i = 1'b1; @(posedge clk); #1; stop_i = 1'b0;
        rdr[0][1] = rw[0];
        chk("R6 store busy", busy_o, 1);
        while (busy_o) @(negedge clk);
        read_dr("R6 pot0 setting1", 0, 1);
    endtask

    task automatic t_global();
        do_start(); do_byte(8'h14); do_stop();
        rw[0] = rdr[0][0]; rw[1] = rdr[1][0];
        chk_wipers("R7 global recall");
        do_start(); do_byte(8'h87);
        @(negedge clk); stop_i = 1'b1; @(posedge clk); #1; stop_i = 1'b0;
        rdr[0][3] = rw[0]; rdr[1][3] = rw[1];
        chk("R7 global store busy", busy_o, 1);
        while (busy_o) @(negedge clk);
        read_dr("R7 pot0 setting3", 0, 3);
        read_dr("R7 pot1 setting3", 1, 3);
    endtask

    task automatic t_incdec();
        do_start(); do_byte(8'h20);
        chk("R9 mode on", incdec_o, 1);
        do_step(1'b1); do_step(1'b1); do_step(1'b0);
        rw[0] = rw[0] + 1;
        chk_wipers("R9 steps pot0");
        do_stop();
        chk("R9 mode off", incdec_o, 0);
        do_step(1'b1);
        chk_wipers("R9 step outside mode");
        do_start(); do_byte(8'hA4); do_byte(8'h01); do_stop(); rw[1] = 1;
        do_start(); do_byte(8'h24);
        do_step(1'b0); do_step(1'b0); do_step(1'b0);
        rw[1] = 0;
        chk_wipers("R9 saturate low");
        do_stop();
        do_start(); do_byte(8'hA4); do_byte(8'h3E); do_stop(); rw[1] = 62;
        do_start(); do_byte(8'h24);
        do_step(1'b1); do_step(1'b1); do_step(1'b1);
        rw[1] = 63;
        chk_wipers("R9 saturate high");
        do_stop();
    endtask

    task automatic t_undef();
        do_start(); do_byte(8'h30); do_byte(8'h05); do_stop();
        chk_wipers("R10 undefined opcode");
        chk("R10 no busy", busy_o, 0);
        do_start(); do_byte(8'hA0); do_byte(8'h05);
        do_start(); do_stop();
        chk_wipers("R10 repeated start discards");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_write_wcr();
        t_write_dr();
        t_xfr();
        t_global();
        t_incdec();
        t_undef();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule